// File: doc/BRIEF.md
# Priority-Level Interrupt Pending Controller

This block keeps track of interrupt requests arranged as a set of priority levels, each level holding a word of independent sources. Commands to post or clear one source arrive with a level number and a source index. A separate clear-all command empties everything. For each level, the block keeps a summary bit that is set whenever any source at that level is waiting.

On every clock the block combines two kinds of request into one candidate priority level. The first is a software request vector. Each of its bits inside the software range maps to a small level number. The second is the summary bits inside the external range, which map to their own bit position. An external request always outranks a software one. When the candidate is above the current priority input, the block raises an interrupt-take output and latches the candidate level and a mask of the contributing bits into a held-info register.

An acknowledge strobe moves the held info to the status and ID outputs. A separate check output reports that something is pending while the program counter is word aligned.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post command with level below NUM_LVL and index below NUM_SRC sets that source's pending bit, and the level's bit in `summary` reads 1 from the cycle after the command.
- R2: A clear command removes only its own source's pending bit. The level's `summary` bit drops, one cycle after the command, only if no other source at that level is still pending.
- R3: `clr_all` empties every pending word and zeroes `summary` one cycle later. It overrides any post or clear issued in the same cycle.
- R4: When a post and a clear name the same level and index in the same cycle, the clear wins and the bit ends up not pending.
- R5: A post or clear with level >= NUM_LVL or index >= NUM_SRC changes no pending state. It makes `cmd_err` read 1 for exactly the following cycle.
- R6: `irq_check` reads 1 in the cycle after a cycle in which `summary` was nonzero and `pc_low` was 2'b00. Otherwise it reads 0.
- R7: A set bit i of `sw_req`, with SW_LO <= i <= SW_HI, gives candidate level i-SW_LO+1 and sets bit i of the mask. The highest such bit gives the software level. Bits of `sw_req` outside that range are ignored.
- R8: A set `summary` bit i, with EXT_LO <= i <= EXT_HI, gives candidate level i and sets mask bit i. The highest such bit wins, and it replaces any software level.
- R9: `irq_take` reads 1 in the cycle after a cycle whose candidate level was nonzero and strictly greater than `cur_ipl`.
- R10: A take loads the candidate level and mask into the held info and sets `info_vld`. An `ack` while `info_vld` is 1 copies the held mask to `isr` and the held level to `intid`, and clears `info_vld` unless a take occurs in the same cycle. A take in the same cycle loads the new info after the old info is committed. An `ack` while `info_vld` is 0 changes nothing.
- R11: A synchronous active-high `rst` sets every pending bit and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| post_vld | input | 1 | Post command strobe |
| post_lvl | input | LIW ($clog2(NUM_LVL)+1) | Level of the post command |
| post_src | input | SIW ($clog2(NUM_SRC)+1) | Source index of the post command |
| clr_vld | input | 1 | Clear command strobe |
| clr_lvl | input | LIW | Level of the clear command |
| clr_src | input | SIW | Source index of the clear command |
| clr_all | input | 1 | Clear every pending source |
| sw_req | input | NUM_LVL | Software request vector |
| cur_ipl | input | $clog2(NUM_LVL) | Current interrupt priority level |
| pc_low | input | 2 | Two low bits of the program counter |
| ack | input | 1 | Commit held info to status and ID |
| summary | output | NUM_LVL | Per-level pending summary |
| irq_check | output | 1 | Pending while the program counter is aligned |
| irq_take | output | 1 | Interrupt taken in the previous cycle |
| info_vld | output | 1 | Held info waiting for acknowledge |
| isr | output | NUM_LVL | Committed summary mask |
| intid | output | $clog2(NUM_LVL) | Committed winning level |
| cmd_err | output | 1 | Out-of-range command seen in the previous cycle |

## Verification
Two functions can fall in the same cycle: a new take that loads the held info, and an acknowledge that commits the held info. The bench provokes this by posting a second, higher external level and holding `ack` high while the resulting take is being evaluated. It then checks that `isr` and `intid` carry the first interrupt while `info_vld` stays set with the second. A post and a clear of the same bit are also issued together, and so are a post and a clear-all. A reference model judges all of these, and a long random phase, by comparing every output on every clock.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int DEF_NUM_LVL = 32;
  localparam int DEF_NUM_SRC = 64;
  localparam int DEF_SW_LO   = 1;
  localparam int DEF_SW_HI   = 15;
  localparam int DEF_EXT_LO  = 16;
  localparam int DEF_EXT_HI  = 31;

  // one-hot decode of an index into a source word
  function automatic logic [DEF_NUM_SRC-1:0] src_onehot(input int unsigned idx);
    logic [DEF_NUM_SRC-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_LVL = 32,
  parameter int NUM_SRC = 64,
  localparam int LW  = $clog2(NUM_LVL),
  localparam int SW  = $clog2(NUM_SRC),
  localparam int LIW = LW + 1,
  localparam int SIW = SW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld_i,
  input  logic [LIW-1:0]     post_lvl_i,
  input  logic [SIW-1:0]     post_src_i,
  input  logic               clr_vld_i,
  input  logic [LIW-1:0]     clr_lvl_i,
  input  logic [SIW-1:0]     clr_src_i,
  input  logic               clr_all_i,
  output logic [NUM_LVL-1:0] summary_o,
  output logic               cmd_err_o
);
  localparam logic [LIW-1:0] LVL_LIM = LIW'(NUM_LVL);
  localparam logic [SIW-1:0] SRC_LIM = SIW'(NUM_SRC);

  logic post_ok, clr_ok, post_bad, clr_bad;
  logic [NUM_SRC-1:0] post_hot, clr_hot;
  logic [NUM_LVL-1:0] sum_next;
  logic [NUM_LVL-1:0] summary_q;
  logic               err_q;

  assign post_ok  = post_vld_i && (post_lvl_i < LVL_LIM) && (post_src_i < SRC_LIM);
  assign clr_ok   = clr_vld_i  && (clr_lvl_i  < LVL_LIM) && (clr_src_i  < SRC_LIM);
  assign post_bad = post_vld_i && !post_ok;
  assign clr_bad  = clr_vld_i  && !clr_ok;

  assign post_hot = NUM_SRC'(1) << post_src_i[SW-1:0];
  assign clr_hot  = NUM_SRC'(1) << clr_src_i[SW-1:0];

  // one pending word per level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] word_q, word_next, set_v, clr_v;
    assign set_v = (post_ok && post_lvl_i[LW-1:0] == LW'(l)) ? post_hot : '0;
    assign clr_v = (clr_ok  && clr_lvl_i[LW-1:0]  == LW'(l)) ? clr_hot  : '0;
    // clear wins over post on the same bit
    assign word_next = clr_all_i ? '0 : ((word_q | set_v) & ~clr_v);
    assign sum_next[l] = |word_next;

    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= word_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      summary_q <= '0;
      err_q     <= 1'b0;
    end else begin
      summary_q <= sum_next;
      err_q     <= post_bad || clr_bad;
    end
  end

  assign summary_o = summary_q;
  assign cmd_err_o = err_q;

  // R5
  bad_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
    (post_bad || clr_bad) |=> err_q);
  // R5
  good_cmd_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    (!post_bad && !clr_bad) |=> !err_q);
  // R3
  clr_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all_i |=> (summary_q == '0));
  // R1
  post_sets_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all_i &&
     !(clr_ok && clr_lvl_i == post_lvl_i && clr_src_i == post_src_i))
    |=> summary_q[$past(post_lvl_i[LW-1:0])]);
  // R5
  bad_post_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (post_bad && !clr_vld_i && !clr_all_i) |=> (summary_q == $past(summary_q)));
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval #(
  parameter int NUM_LVL = 32,
  parameter int SW_LO   = 1,
  parameter int SW_HI   = 15,
  parameter int EXT_LO  = 16,
  parameter int EXT_HI  = 31,
  localparam int LW = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] summary_i,
  input  logic [NUM_LVL-1:0] sw_req_i,
  input  logic [LW-1:0]      cur_ipl_i,
  output logic [LW-1:0]      cand_lvl_o,
  output logic [NUM_LVL-1:0] cand_mask_o,
  output logic               take_o
);
  logic [LW-1:0]      sw_lvl, ext_lvl;
  logic [NUM_LVL-1:0] sw_mask, ext_mask;

  // software range: later (higher) bits overwrite earlier ones
  always_comb begin
    sw_lvl  = '0;
    sw_mask = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req_i[i]) begin
        sw_lvl     = LW'(i - SW_LO + 1);
        sw_mask[i] = 1'b1;
      end
    end
  end

  // external range: bit position is the level
  always_comb begin
    ext_lvl  = '0;
    ext_mask = '0;
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (summary_i[i]) begin
        ext_lvl     = LW'(i);
        ext_mask[i] = 1'b1;
      end
    end
  end

  assign cand_lvl_o  = (ext_mask != '0) ? ext_lvl : sw_lvl;
  assign cand_mask_o = sw_mask | ext_mask;
  assign take_o      = (cand_lvl_o != '0) && (cand_lvl_o > cur_ipl_i);
endmodule

// File: rtl/irq_info_commit.sv
module irq_info_commit #(
  parameter int NUM_LVL = 32,
  localparam int LW = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic [LW-1:0]      cand_lvl_i,
  input  logic [NUM_LVL-1:0] cand_mask_i,
  input  logic               ack_i,
  output logic               irq_take_o,
  output logic               info_vld_o,
  output logic [NUM_LVL-1:0] isr_o,
  output logic [LW-1:0]      intid_o
);
  logic               take_q, vld_q;
  logic [LW-1:0]      hold_lvl_q, intid_q;
  logic [NUM_LVL-1:0] hold_mask_q, isr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q      <= 1'b0;
      vld_q       <= 1'b0;
      hold_lvl_q  <= '0;
      hold_mask_q <= '0;
      isr_q       <= '0;
      intid_q     <= '0;
    end else begin
      take_q <= take_i;
      if (ack_i && vld_q) begin
        isr_q   <= hold_mask_q;
        intid_q <= hold_lvl_q;
      end
      if (take_i) begin
        vld_q       <= 1'b1;
        hold_lvl_q  <= cand_lvl_i;
        hold_mask_q <= cand_mask_i;
      end else if (ack_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign irq_take_o = take_q;
  assign info_vld_o = vld_q;
  assign isr_o      = isr_q;
  assign intid_o    = intid_q;

  // R10
  take_loads_info_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (vld_q && take_q));
  // R10
  ack_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && vld_q) |=> (isr_q == $past(hold_mask_q) && intid_q == $past(hold_lvl_q)));
  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !vld_q && !take_i) |=> ($stable(isr_q) && $stable(intid_q) && !vld_q));
  // R9
  take_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (hold_lvl_q != '0));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int SW_LO   = DEF_SW_LO,
  parameter int SW_HI   = DEF_SW_HI,
  parameter int EXT_LO  = DEF_EXT_LO,
  parameter int EXT_HI  = DEF_EXT_HI,
  localparam int LW  = $clog2(NUM_LVL),
  localparam int LIW = LW + 1,
  localparam int SIW = $clog2(NUM_SRC) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [LIW-1:0]     post_lvl,
  input  logic [SIW-1:0]     post_src,
  input  logic               clr_vld,
  input  logic [LIW-1:0]     clr_lvl,
  input  logic [SIW-1:0]     clr_src,
  input  logic               clr_all,
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [LW-1:0]      cur_ipl,
  input  logic [1:0]         pc_low,
  input  logic               ack,
  output logic [NUM_LVL-1:0] summary,
  output logic               irq_check,
  output logic               irq_take,
  output logic               info_vld,
  output logic [NUM_LVL-1:0] isr,
  output logic [LW-1:0]      intid,
  output logic               cmd_err
);
  logic [NUM_LVL-1:0] sum_w, cand_mask;
  logic [LW-1:0]      cand_lvl;
  logic               take_w, check_q;

  irq_pend_bank #(.NUM_LVL(NUM_LVL), .NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst),
    .post_vld_i(post_vld), .post_lvl_i(post_lvl), .post_src_i(post_src),
    .clr_vld_i(clr_vld), .clr_lvl_i(clr_lvl), .clr_src_i(clr_src),
    .clr_all_i(clr_all), .summary_o(sum_w), .cmd_err_o(cmd_err)
  );

  irq_prio_eval #(.NUM_LVL(NUM_LVL), .SW_LO(SW_LO), .SW_HI(SW_HI),
                  .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_eval (
    .summary_i(sum_w), .sw_req_i(sw_req), .cur_ipl_i(cur_ipl),
    .cand_lvl_o(cand_lvl), .cand_mask_o(cand_mask), .take_o(take_w)
  );

  irq_info_commit #(.NUM_LVL(NUM_LVL)) u_commit (
    .clk(clk), .rst(rst), .take_i(take_w), .cand_lvl_i(cand_lvl),
    .cand_mask_i(cand_mask), .ack_i(ack), .irq_take_o(irq_take),
    .info_vld_o(info_vld), .isr_o(isr), .intid_o(intid)
  );

  always_ff @(posedge clk) begin
    if (rst) check_q <= 1'b0;
    else     check_q <= (sum_w != '0) && (pc_low == 2'b00);
  end

  assign summary   = sum_w;
  assign irq_check = check_q;

  // R6
  check_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    check_q |-> ($past(sum_w) != '0 && $past(pc_low) == 2'b00));
  // R9
  take_above_ipl_chk: assert property (@(posedge clk) disable iff (rst)
    (sum_w == '0 && sw_req == '0) |=> !irq_take);
  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (sum_w == '0 && !info_vld && isr == '0 && intid == '0 && !check_q));
endmodule

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;
  localparam int NL = 32;
  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        post_vld, clr_vld, clr_all, ack;
  logic [5:0]  post_lvl, clr_lvl;
  logic [6:0]  post_src, clr_src;
  logic [31:0] sw_req;
  logic [4:0]  cur_ipl;
  logic [1:0]  pc_low;
  logic [31:0] summary, isr;
  logic        irq_check, irq_take, info_vld, cmd_err;
  logic [4:0]  intid;

  always #10 clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_lvl(post_lvl), .post_src(post_src),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_src(clr_src), .clr_all(clr_all),
    .sw_req(sw_req), .cur_ipl(cur_ipl), .pc_low(pc_low), .ack(ack),
    .summary(summary), .irq_check(irq_check), .irq_take(irq_take),
    .info_vld(info_vld), .isr(isr), .intid(intid), .cmd_err(cmd_err)
  );

  // reference model state
  logic [NS-1:0] m_pend [NL];
  logic [31:0]   m_sum, m_imask, m_isr;
  logic [4:0]    m_ilvl, m_id;
  logic          m_chk, m_take, m_vld, m_err;
  int total = 0, bad = 0;

  task automatic model_step();
    int lvl;
    logic [31:0] mask;
    logic tk;
    if (rst) begin
      for (int l = 0; l < NL; l++) m_pend[l] = '0;
      m_sum = 0; m_imask = 0; m_isr = 0; m_ilvl = 0; m_id = 0;
      m_chk = 0; m_take = 0; m_vld = 0; m_err = 0;
      return;
    end
    lvl = 0; mask = 0;
    for (int i = 15; i >= 1; i--) if (sw_req[i]) begin
      mask[i] = 1'b1; if (lvl == 0) lvl = i;
    end
    begin
      int e = 0;
      for (int i = 31; i >= 16; i--) if (m_sum[i]) begin
        mask[i] = 1'b1; if (e == 0) e = i;
      end
      if (e != 0) lvl = e;
    end
    tk = (lvl != 0) && (lvl > int'(cur_ipl));
    m_chk = (m_sum != 0) && (pc_low == 2'b00);
    if (ack && m_vld) begin m_isr = m_imask; m_id = m_ilvl; end
    if (tk) begin m_vld = 1; m_ilvl = 5'(lvl); m_imask = mask; end
    else if (ack) m_vld = 0;
    m_take = tk;
    m_err = (post_vld && (post_lvl >= 32 || post_src >= 64)) ||
            (clr_vld && (clr_lvl >= 32 || clr_src >= 64));
    if (clr_all) begin
      for (int l = 0; l < NL; l++) m_pend[l] = '0;
    end else begin
      if (post_vld && post_lvl < 32 && post_src < 64) m_pend[post_lvl[4:0]][post_src[5:0]] = 1'b1;
      if (clr_vld && clr_lvl < 32 && clr_src < 64) m_pend[clr_lvl[4:0]][clr_src[5:0]] = 1'b0;
    end
    for (int l = 0; l < NL; l++) m_sum[l] = (m_pend[l] != 0);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string ph);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (%s) got=%h exp=%h t=%0t", tag, ph, got, exp, $time);
    end
  endtask

  task automatic compare(string ph);
    chk("R1/R2/R3 summary", summary, m_sum, ph);
    chk("R5 cmd_err", {31'd0, cmd_err}, {31'd0, m_err}, ph);
    chk("R6 irq_check", {31'd0, irq_check}, {31'd0, m_chk}, ph);
    chk("R9 irq_take", {31'd0, irq_take}, {31'd0, m_take}, ph);
    chk("R10 info_vld", {31'd0, info_vld}, {31'd0, m_vld}, ph);
    chk("R7/R8 isr", isr, m_isr, ph);
    chk("R8 intid", {27'd0, intid}, {27'd0, m_id}, ph);
  endtask

  task automatic tick(string ph);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(ph);
  endtask

  task automatic idle();
    post_vld = 0; clr_vld = 0; clr_all = 0; ack = 0;
  endtask

  task automatic post(int l, int s);
    post_vld = 1; post_lvl = 6'(l); post_src = 7'(s);
  endtask

  task automatic clr(int l, int s);
    clr_vld = 1; clr_lvl = 6'(l); clr_src = 7'(s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; idle(); post_lvl = 0; post_src = 0; clr_lvl = 0; clr_src = 0;
    sw_req = 0; cur_ipl = 0; pc_low = 0;
    repeat (3) tick("R11 reset");
    rst = 0; tick("R11 idle");
    // R1: post external level 20
    post(20, 3); tick("R1 post");
    idle(); tick("R9 take"); tick("R10 hold");
    ack = 1; tick("R10 ack"); idle(); tick("R10 after ack");
    // R2: second source, clear one then the other
    post(20, 9); tick("R2 post2");
    idle(); clr(20, 3); tick("R2 clr one");
    idle(); tick("R2 stay");
    clr(20, 9); tick("R2 clr last"); idle(); tick("R2 empty");
    // R7: software levels, ipl gating for R9
    sw_req = 32'h0000_0024; cur_ipl = 5; tick("R7 sw eq ipl");
    cur_ipl = 4; tick("R7 sw above"); tick("R9 take sw");
    sw_req = 32'h0001_0001; cur_ipl = 0; tick("R7 out of range");
    ack = 1; tick("R10 ack sw"); idle(); tick("R10 sw done");
    // R8 overrides software; R10 ack and take together
    sw_req = 32'h0000_8000; post(17, 0); tick("R8 post ext");
    idle(); tick("R8 ext wins"); ack = 1; tick("R10 ack1");
    idle(); post(25, 1); tick("R8 post hi");
    ack = 1; tick("R10 ack+take"); tick("R10 ack+take2");
    idle(); ack = 1; tick("R10 ack idle"); idle(); tick("R10 idle");
    ack = 1; tick("R10 ack no vld"); idle(); sw_req = 0;
    // R6: misaligned pc
    pc_low = 2'b10; tick("R6 misaligned"); tick("R6 mis2");
    pc_low = 2'b00; tick("R6 aligned"); tick("R6 aligned2");
    // R5: out-of-range commands
    post(40, 1); tick("R5 bad lvl"); idle(); tick("R5 err");
    clr(25, 70); tick("R5 bad clr"); idle(); tick("R5 err2");
    post(2, 64); tick("R5 bad src"); idle(); tick("R5 err3");
    // R4: same bit post and clear
    post(3, 5); clr(3, 5); tick("R4 collide"); idle(); tick("R4 result");
    // R3: clear-all with concurrent post
    post(30, 2); clr_all = 1; tick("R3 clr all"); idle(); tick("R3 empty");
    // random phase
    for (int n = 0; n < 2000; n++) begin
      idle();
      post_vld = ($urandom_range(0, 2) == 0);
      post_lvl = 6'($urandom_range(0, 35)); post_src = 7'($urandom_range(0, 67));
      clr_vld  = ($urandom_range(0, 2) == 0);
      clr_lvl  = 6'($urandom_range(0, 35)); clr_src = 7'($urandom_range(0, 67));
      if ($urandom_range(0, 7) == 0) begin clr_lvl = post_lvl; clr_src = post_src; end
      clr_all  = ($urandom_range(0, 60) == 0);
      ack      = ($urandom_range(0, 3) == 0);
      sw_req   = ($urandom_range(0, 3) == 0) ? $urandom() : 32'd0;
      cur_ipl  = 5'($urandom_range(0, 31));
      pc_low   = 2'($urandom_range(0, 3));
      rst      = ($urandom_range(0, 500) == 0);
      tick("R11 random");
    end
    rst = 0; idle(); tick("end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule